// File: doc/BRIEF.md
# DRAM refresh interval timer

This block paces DRAM refresh for a memory controller. A free-running prescaler divides the system clock by a ratio chosen with a 3-bit code. An 8-bit interval counter advances once per prescaled tick. When the interval counter equals a programmable limit, the block raises a refresh request and restarts the counter from zero. The request stays up until the controller acknowledges it. When an acknowledge is accepted in CAS-before-RAS operation, the block plays out the column/row strobe sequence that the memory needs for such a refresh.

A global enable and a mode input pick the operating state. With the enable low, everything is held at rest. With the enable high and the mode low, periodic CAS-before-RAS refresh runs. With the enable high and the mode high, the DRAM refreshes itself. In that state the block raises a self-refresh flag and issues no requests and no strobes. A request that is still waiting when the next interval expires sets a sticky overrun flag, so the controller can detect that it is falling behind.

Top module: `dram_refresh_timer`

## Requirements
- R1: After reset, req_o, overrun_o, cas_o, ras_o and self_rfsh_o are all 0.
- R2: rate_sel_i selects the tick divisor: code 0 gives 2, code 1 gives 8, code 2 gives 32, code 3 gives 128, code 4 gives 512, code 5 gives 2048, code 6 gives 4096 and code 7 gives 1 (every clock). With limit L and divisor D, req_o first reads 1 exactly (L+1)*D clock edges after the first edge that samples CBR operation enabled.
- R3: On a match, the counter restarts from zero. While CBR operation stays enabled, each later request rises (L+1)*D edges after the previous one.
- R4: While rfsh_en_i is 0, the prescaler and the counter are held at zero and req_o and overrun_o are cleared. After re-enabling, the first request takes a full (L+1)*D interval.
- R5: req_o stays 1 until an edge samples ack_i at 1 while the strobe sequencer is idle. req_o reads 0 after that edge, unless a new match occurs on the same edge.
- R6: A match on an edge where a request is pending and not being accepted sets overrun_o. overrun_o then stays 1 until CBR operation is left (the enable goes low or the mode goes high).
- R7: After an accepting edge, the strobes read as follows, all of them active high: cas_o=1 and ras_o=0 for one cycle, then both 1 for two cycles, then cas_o=0 and ras_o=1 for one cycle, then both 0.
- R8: With rfsh_en_i=1 and self_mode_i=1, self_rfsh_o reads 1 from the next edge on, and no requests and no strobes are produced.
- R9: An acknowledge that arrives while no request is pending does not start a strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rfsh_en_i | input | 1 | Refresh function enable |
| self_mode_i | input | 1 | 0 = CAS-before-RAS refresh, 1 = self-refresh |
| rate_sel_i | input | 3 | Prescaler divisor code |
| limit_i | input | CNT_W | Interval compare value |
| ack_i | input | 1 | Controller acknowledge of a pending request |
| req_o | output | 1 | Refresh request, held until accepted |
| overrun_o | output | 1 | Sticky flag: an interval expired with a request still pending |
| cas_o | output | 1 | Column strobe, active high |
| ras_o | output | 1 | Row strobe, active high |
| self_rfsh_o | output | 1 | Self-refresh state flag |

## Verification
Every divisor code is run with small limits. The request arrival times are compared, to the exact clock, against (L+1)*D from the enable edge and between successive requests. This separates a wrong code mapping, an off-by-one compare and a counter that fails to restart. Further patterns cover:
- holding the acknowledge back, which separates a held request from a pulsed one and shows when overrun begins;
- a manual acknowledge, traced edge by edge against the strobe order;
- a disable in the middle of an interval, which shows that the count is cleared and not paused;
- self-refresh mode and a stray acknowledge, both of which must leave the outputs quiet.

// File: rtl/rfsh_timer_pkg.sv
package rfsh_timer_pkg;

   localparam int unsigned SEL_W     = 3;
   localparam int unsigned NUM_RATES = 1 << SEL_W;
   localparam int unsigned PRE_W     = 12;

   typedef enum logic [1:0] {
      CBR_IDLE = 2'd0,
      CBR_LEAD = 2'd1,
      CBR_BOTH = 2'd2,
      CBR_TAIL = 2'd3
   } cbr_state_e;

   // log2 of the divisor for each select code; 0 means every clock
   function automatic int unsigned rate_exp(input int unsigned code);
      case (code)
         0:       return 1;
         1:       return 3;
         2:       return 5;
         3:       return 7;
         4:       return 9;
         5:       return 11;
         6:       return 12;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler
   import rfsh_timer_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);

   logic [PRE_W-1:0]     pre_q;
   logic [NUM_RATES-1:0] tick_vec;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
      end else if (!run_i) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
      localparam int unsigned E = rate_exp(g);
      if (E > PRE_W) begin : g_bad
         $error("prescaler too narrow for rate %0d", g);
      end else if (E == 0) begin : g_every
         assign tick_vec[g] = 1'b1;
      end else begin : g_div
         assign tick_vec[g] = &pre_q[E-1:0];
      end
   end

   assign tick_o = run_i & tick_vec[sel_i];

endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             match_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   assign hit     = tick_i & (cnt_q == limit_i);
   assign match_o = run_i & hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!run_i || hit) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rfsh_request.sv
module rfsh_request (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic match_i,
   input  logic accept_i,
   output logic req_o,
   output logic ovr_o
);

   logic req_q;
   logic ovr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q <= 1'b0;
         ovr_q <= 1'b0;
      end else if (!run_i) begin
         req_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (match_i) begin
            req_q <= 1'b1;
         end else if (accept_i) begin
            req_q <= 1'b0;
         end
         if (match_i && req_q && !accept_i) begin
            ovr_q <= 1'b1;
         end
      end
   end

   assign req_o = req_q;
   assign ovr_o = ovr_q;

endmodule

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
   import rfsh_timer_pkg::*;
#(
   parameter int unsigned HOLD_CYC = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic idle_o,
   output logic cas_o,
   output logic ras_o
);

   localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

   if (HOLD_CYC < 1) begin : g_chk_hold
      $error("HOLD_CYC must be at least 1");
   end

   cbr_state_e    state_q;
   logic [HW-1:0] hold_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= CBR_IDLE;
         hold_q  <= '0;
      end else begin
         case (state_q)
            CBR_IDLE: if (start_i) state_q <= CBR_LEAD;
            CBR_LEAD: begin
               state_q <= CBR_BOTH;
               hold_q  <= '0;
            end
            CBR_BOTH: begin
               if (hold_q == HW'(HOLD_CYC - 1)) begin
                  state_q <= CBR_TAIL;
               end else begin
                  hold_q <= hold_q + 1'b1;
               end
            end
            default:  state_q <= CBR_IDLE;
         endcase
      end
   end

   assign idle_o = (state_q == CBR_IDLE);
   assign cas_o  = (state_q == CBR_LEAD) || (state_q == CBR_BOTH);
   assign ras_o  = (state_q == CBR_BOTH) || (state_q == CBR_TAIL);

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer
   import rfsh_timer_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned HOLD_CYC = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rfsh_en_i,
   input  logic             self_mode_i,
   input  logic [SEL_W-1:0] rate_sel_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic             overrun_o,
   output logic             cas_o,
   output logic             ras_o,
   output logic             self_rfsh_o
);

   if (CNT_W < 1) begin : g_chk_cnt
      $error("CNT_W must be at least 1");
   end

   logic run_cbr;
   logic tick;
   logic match;
   logic seq_idle;
   logic accept;
   logic req_int;
   logic self_q;

   assign run_cbr = rfsh_en_i & ~self_mode_i;
   assign accept  = req_int & ack_i & seq_idle;

   rfsh_prescaler u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_cbr),
      .sel_i  (rate_sel_i),
      .tick_o (tick)
   );

   rfsh_interval #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_cbr),
      .tick_i  (tick),
      .limit_i (limit_i),
      .match_o (match)
   );

   rfsh_request u_req (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_cbr),
      .match_i  (match),
      .accept_i (accept),
      .req_o    (req_int),
      .ovr_o    (overrun_o)
   );

   rfsh_cbr_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (accept),
      .idle_o  (seq_idle),
      .cas_o   (cas_o),
      .ras_o   (ras_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         self_q <= 1'b0;
      end else begin
         self_q <= rfsh_en_i & self_mode_i;
      end
   end

   assign req_o       = req_int;
   assign self_rfsh_o = self_q;

endmodule

// File: rtl/dram_refresh_timer_chk.sv
module dram_refresh_timer_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic rfsh_en_i,
   input logic self_mode_i,
   input logic ack_i,
   input logic req_o,
   input logic overrun_o,
   input logic cas_o,
   input logic ras_o,
   input logic self_rfsh_o
);

   p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && !ack_i && rfsh_en_i && !self_mode_i) |=> req_o);

   p_off_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rfsh_en_i |=> (!req_o && !overrun_o));

   p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (overrun_o && rfsh_en_i && !self_mode_i) |=> overrun_o);

   p_ovr_needs_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(overrun_o) |-> $past(req_o));

   p_cas_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cas_o) |-> !ras_o);

   p_ras_after_cas_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ras_o) |-> (cas_o && $past(cas_o)));

   p_cas_drops_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cas_o) |-> ras_o);

   p_self_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      self_rfsh_o |-> !req_o);

   p_idle_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_o && !cas_o && !ras_o) |=> !cas_o);

endmodule

bind dram_refresh_timer dram_refresh_timer_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .rfsh_en_i   (rfsh_en_i),
   .self_mode_i (self_mode_i),
   .ack_i       (ack_i),
   .req_o       (req_o),
   .overrun_o   (overrun_o),
   .cas_o       (cas_o),
   .ras_o       (ras_o),
   .self_rfsh_o (self_rfsh_o)
);

// File: tb/dram_refresh_timer_tb_top.sv
module dram_refresh_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       mode = 1'b0;
   logic [2:0] sel = 3'd7;
   logic [7:0] limit = 8'd0;
   logic       ack_auto = 1'b0;
   logic       ack_man = 1'b0;
   logic       ack;
   logic       req, ovr, cas, ras, selfr;

   int   cyc = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   int   exp_q[$];
   bit   auto_en = 1'b0;
   logic req_prev = 1'b0;
   string cur_tag = "R2";

   always #4 clk = ~clk;

   assign ack = ack_auto | ack_man;

   dram_refresh_timer dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .rfsh_en_i   (en),
      .self_mode_i (mode),
      .rate_sel_i  (sel),
      .limit_i     (limit),
      .ack_i       (ack),
      .req_o       (req),
      .overrun_o   (ovr),
      .cas_o       (cas),
      .ras_o       (ras),
      .self_rfsh_o (selfr)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: each request rise is popped against the expected edge count
   always @(negedge clk) begin
      if (rst_n) begin
         if (req && !req_prev) begin : pop
            int e;
            n_cmp++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL %s: unexpected request at cycle %0d (expected none)", cur_tag, cyc);
            end else begin
               e = exp_q.pop_front();
               if (e != cyc) begin
                  n_bad++;
                  $display("FAIL %s: request at cycle %0d, expected %0d", cur_tag, cyc, e);
               end
            end
         end
         req_prev <= req;
      end
   end

   always @(negedge clk) ack_auto <= auto_en && req && !ack_auto;

   function automatic int divisor(input int code);
      case (code)
         0: return 2;
         1: return 8;
         2: return 32;
         3: return 128;
         4: return 512;
         5: return 2048;
         6: return 4096;
         default: return 1;
      endcase
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: got %0d, expected %0d", tag, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // driver: programs a rate, pushes the expected request edges, then stops
   task automatic run_rate(input int code, input int lim, input int n, input string tag);
      int per;
      int s;
      @(negedge clk);
      cur_tag = tag;
      sel = 3'(code);
      limit = 8'(lim);
      mode = 1'b0;
      auto_en = 1'b1;
      per = (lim + 1) * divisor(code);
      s = cyc;
      en = 1'b1;
      for (int k = 1; k <= n; k++) exp_q.push_back(s + k * per);
      wait_until(s + n * per + 2);
      en = 1'b0;
      step(6);
      auto_en = 1'b0;
      check(tag, exp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run hung at cycle %0d (expected completion)", cyc);
      finish_run();
   end

   initial begin : main
      int s;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1: reset state
      check("R1 req", req, 0);
      check("R1 ovr", ovr, 0);
      check("R1 cas", cas, 0);
      check("R1 ras", ras, 0);
      check("R1 self", selfr, 0);

      // R2 / R3: each divisor code, several intervals back to back
      run_rate(7, 5, 3, "R3 div1");
      run_rate(0, 3, 3, "R2 div2");
      run_rate(1, 2, 3, "R2 div8");
      run_rate(2, 1, 3, "R2 div32");
      run_rate(3, 0, 3, "R2 div128");
      run_rate(4, 0, 2, "R2 div512");
      run_rate(5, 0, 2, "R2 div2048");
      run_rate(6, 1, 2, "R3 div4096");

      // R4: disabled with a tiny limit, nothing happens
      cur_tag = "R4 off";
      sel = 3'd7; limit = 8'd0;
      step(300);
      check("R4 off req", req, 0);

      // R4: disable mid-interval, re-enable restarts a full interval
      cur_tag = "R4 restart";
      limit = 8'd9;
      auto_en = 1'b1;
      en = 1'b1;
      step(5);
      en = 1'b0;
      step(1);
      s = cyc;
      en = 1'b1;
      exp_q.push_back(s + 10);
      wait_until(s + 12);
      en = 1'b0;
      step(6);
      auto_en = 1'b0;
      check("R4 restart", exp_q.size(), 0);

      // R6: requests left unacknowledged
      cur_tag = "R6";
      limit = 8'd2;
      s = cyc;
      en = 1'b1;
      exp_q.push_back(s + 3);
      wait_until(s + 5);
      check("R6 ovr before 2nd match", ovr, 0);
      check("R5 req held", req, 1);
      step(1);
      check("R6 ovr on 2nd match", ovr, 1);
      wait_until(s + 9);
      check("R6 ovr sticky", ovr, 1);
      en = 1'b0;
      step(1);
      check("R4 ovr cleared", ovr, 0);
      check("R4 req cleared", req, 0);
      step(3);

      // R5 / R7: manual acknowledge and strobe trace
      cur_tag = "R5";
      limit = 8'd7;
      s = cyc;
      en = 1'b1;
      exp_q.push_back(s + 8);
      exp_q.push_back(s + 16);
      wait_until(s + 11);
      check("R5 req waits for ack", req, 1);
      check("R7 no strobe before ack", cas, 0);
      ack_man = 1'b1;
      step(1);
      ack_man = 1'b0;
      check("R5 req dropped", req, 0);
      check("R7 lead cas", cas, 1);
      check("R7 lead ras", ras, 0);
      step(1);
      check("R7 both1 cas", cas, 1);
      check("R7 both1 ras", ras, 1);
      step(1);
      check("R7 both2 cas", cas, 1);
      check("R7 both2 ras", ras, 1);
      step(1);
      check("R7 tail cas", cas, 0);
      check("R7 tail ras", ras, 1);
      step(1);
      check("R7 end cas", cas, 0);
      check("R7 end ras", ras, 0);
      check("R3 next req", req, 1);
      en = 1'b0;
      step(3);

      // R8: self-refresh mode
      cur_tag = "R8";
      limit = 8'd0;
      mode = 1'b1;
      en = 1'b1;
      step(1);
      check("R8 self flag", selfr, 1);
      for (int i = 0; i < 50; i++) begin
         step(1);
         if (req || cas || ras) check("R8 quiet", {req, cas, ras}, 0);
      end
      check("R8 req", req, 0);
      check("R8 cas", cas, 0);
      en = 1'b0;
      mode = 1'b0;
      step(1);
      check("R8 flag off", selfr, 0);

      // R9: acknowledge with nothing pending
      cur_tag = "R9";
      ack_man = 1'b1;
      for (int i = 0; i < 4; i++) begin
         step(1);
         check("R9 cas", cas, 0);
         check("R9 ras", ras, 0);
      end
      ack_man = 1'b0;
      step(2);

      check("R2 queue drained", exp_q.size(), 0);
      finish_run();
   end

endmodule